// File: doc/BRIEF.md
# PLL divisor search engine

This block searches for a divisor set for a display clock synthesiser. A start pulse captures a target dot-clock frequency and a reference frequency. The engine then visits candidate settings of the pre-divider N, the two feedback factors M1 and M2, and the post-divider P1, with the second post-divider P2 fixed by a parameter. Each candidate is screened against range limits. The engine then computes the resulting dot clock with a bit-serial divider.

The search stops at the first candidate whose dot clock equals the target. If no candidate matches exactly, the result is the candidate whose dot clock lies above the target and is closest to it. The outputs are the chosen divisors, a packed divisor word ready for a configuration register, and busy, done and valid flags. Programming the synthesiser and waiting for it to lock are handled elsewhere.

Top module: `pll_div_search`

## Requirements
- R1: After reset, busy, done and valid are low, and every divisor output and the divisor word are zero.
- R2: A start pulse seen while busy is low captures the target and reference inputs. busy is high from the next cycle until the search ends, and busy and done are never high together.
- R3: A start pulse that arrives while busy is high is ignored, and the result belongs to the inputs captured by the earlier start.
- R4: A candidate is legal only when all of the following hold: M1 > M2, the combined M lies in 70..120, the combined P lies in 5..80, the VCO frequency lies in its parameter window (1.4–2.8 GHz by default) and the dot clock lies in its window (20–400 MHz by default). A reported result is always legal.
- R5: Candidates are visited with N ascending from its minimum as the outermost loop, then M1, M2 and P1 each descending from their maximum, nested in that order. The first candidate whose dot clock equals the target ends the search at once and is reported.
- R6: When no exact match exists, the result is the legal candidate with the smallest dot clock strictly above the target. On a tie, the candidate visited first wins. The running best difference starts at all ones (0xFFFFFFFF for 32-bit frequencies).
- R7: When no legal candidate qualifies, done rises with valid low, and the divisor outputs and the divisor word read zero. valid is never high while done is low.
- R8: The divisor word holds M2−2 in bits 7:0, M1−2 in bits 15:8 and N−2 in bits 23:16.
- R9: M = 5·(M1+2) + (M2+2), P = P1·P2 (P2 = 10 by default), VCO = floor(ref·M/(N+2)) and dot = floor(VCO/P).
- R10: done, valid, the divisors and the word hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search with the present target and reference |
| targetFreq | input | FREQ_W | Wanted dot-clock frequency |
| refFreq | input | FREQ_W | Reference clock frequency, same unit as the target |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, result stable |
| valid | output | 1 | A qualifying candidate was found |
| nOut | output | 8 | Chosen N |
| m1Out | output | 8 | Chosen M1 |
| m2Out | output | 8 | Chosen M2 |
| p1Out | output | 8 | Chosen P1 |
| divWord | output | 24 | Packed divisor word |

## Verification
The bench keeps the default divisor ranges and P2, so the full loop order and every range rule are exercised. The frequency windows are scaled to kHz: VCO from 1 400 000 to 2 800 000 and dot clock from 20 000 to 400 000. This cuts the divider to 19 steps, which makes several complete searches of all 2640 candidates fit the run. A 96 000 reference reaches the exact-match exit, the above-target fallback and the out-of-range target. A 10 000 reference puts every candidate outside the VCO window.

// File: rtl/pll_div_search_pkg.sv
package pll_div_search_pkg;

  localparam int FIELD_W = 8;

  typedef logic [FIELD_W-1:0] field_t;

  typedef struct packed {
    field_t n;
    field_t m1;
    field_t m2;
    field_t p1;
  } cand_t;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic divGo;
    logic judge;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic candOk;
    logic divDone;
    logic exact;
  } status_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_DIV   = 2'd2,
    ST_FIN   = 2'd3
  } state_t;

endpackage

// File: rtl/pll_div_search_ctrl.sv
module pll_div_search_ctrl
  import pll_div_search_pkg::*;
#(
  parameter int N_MIN  = 3,
  parameter int N_MAX  = 8,
  parameter int M1_MIN = 10,
  parameter int M1_MAX = 20,
  parameter int M2_MIN = 5,
  parameter int M2_MAX = 9,
  parameter int P1_MIN = 1,
  parameter int P1_MAX = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  status_t stat,
  output cand_t   cand,
  output strobe_t strobe,
  output logic    busy,
  output logic    done
);

  state_t stateQ;
  cand_t  candQ;
  cand_t  candNext;
  logic   lastCand;

  assign lastCand = (candQ.n  == field_t'(N_MAX))  && (candQ.m1 == field_t'(M1_MIN)) &&
                    (candQ.m2 == field_t'(M2_MIN)) && (candQ.p1 == field_t'(P1_MIN));

  // odometer: P1 fastest (down), then M2 (down), M1 (down), N (up)
  always_comb begin
    candNext = candQ;
    if (candQ.p1 != field_t'(P1_MIN)) begin
      candNext.p1 = candQ.p1 - 1'b1;
    end else begin
      candNext.p1 = field_t'(P1_MAX);
      if (candQ.m2 != field_t'(M2_MIN)) begin
        candNext.m2 = candQ.m2 - 1'b1;
      end else begin
        candNext.m2 = field_t'(M2_MAX);
        if (candQ.m1 != field_t'(M1_MIN)) begin
          candNext.m1 = candQ.m1 - 1'b1;
        end else begin
          candNext.m1 = field_t'(M1_MAX);
          candNext.n  = candQ.n + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      candQ  <= '0;
    end else begin
      case (stateQ)
        ST_IDLE, ST_FIN: begin
          if (start) begin
            stateQ <= ST_CHECK;
            candQ  <= '{n: field_t'(N_MIN), m1: field_t'(M1_MAX),
                        m2: field_t'(M2_MAX), p1: field_t'(P1_MAX)};
          end
        end
        ST_CHECK: begin
          if (stat.candOk)  stateQ <= ST_DIV;
          else if (lastCand) stateQ <= ST_FIN;
          else              candQ  <= candNext;
        end
        ST_DIV: begin
          if (stat.divDone) begin
            if (stat.exact || lastCand) begin
              stateQ <= ST_FIN;
            end else begin
              candQ  <= candNext;
              stateQ <= ST_CHECK;
            end
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load  = ((stateQ == ST_IDLE) || (stateQ == ST_FIN)) && start;
    strobe.divGo = (stateQ == ST_CHECK) && stat.candOk;
    strobe.judge = (stateQ == ST_DIV) && stat.divDone;
  end

  assign cand = candQ;
  assign busy = (stateQ == ST_CHECK) || (stateQ == ST_DIV);
  assign done = (stateQ == ST_FIN);

endmodule

// File: rtl/pll_div_search_dp.sv
module pll_div_search_dp
  import pll_div_search_pkg::*;
#(
  parameter int FREQ_W   = 32,
  parameter int P2       = 10,
  parameter int MSUM_MIN = 70,
  parameter int MSUM_MAX = 120,
  parameter int PSUM_MIN = 5,
  parameter int PSUM_MAX = 80,
  parameter logic [FREQ_W-1:0] VCO_MIN = 32'd1400000000,
  parameter logic [FREQ_W-1:0] VCO_MAX = 32'd2800000000,
  parameter logic [FREQ_W-1:0] DOT_MIN = 32'd20000000,
  parameter logic [FREQ_W-1:0] DOT_MAX = 32'd400000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FREQ_W-1:0] targetFreq,
  input  logic [FREQ_W-1:0] refFreq,
  input  cand_t             cand,
  input  strobe_t           strobe,
  output status_t           stat,
  output cand_t             best,
  output logic [23:0]       word,
  output logic              found
);

  localparam int CMP_W = FREQ_W + 16;
  localparam int QW    = $clog2(CMP_W'(DOT_MAX) + CMP_W'(1));
  localparam int CW    = $clog2(QW + 1);

  logic [FREQ_W-1:0] tgtQ, refQ, bestDiffQ;
  logic [15:0]       mSum, pSum, nDiv;
  logic [CMP_W-1:0]  prod, dTot;
  logic              vcoOk, dotOk, rangeOk;

  // candidate screen: windows on floor(x/d) become products, no division
  always_comb begin
    mSum  = 16'd5 * (16'(cand.m1) + 16'd2) + 16'(cand.m2) + 16'd2;
    pSum  = 16'(cand.p1) * 16'(P2);
    nDiv  = 16'(cand.n) + 16'd2;
    prod  = CMP_W'(refQ) * CMP_W'(mSum);
    dTot  = CMP_W'(nDiv) * CMP_W'(pSum);
    vcoOk = (prod >= CMP_W'(VCO_MIN) * CMP_W'(nDiv)) &&
            (prod <  (CMP_W'(VCO_MAX) + CMP_W'(1)) * CMP_W'(nDiv));
    dotOk = (prod >= CMP_W'(DOT_MIN) * dTot) &&
            (prod <  (CMP_W'(DOT_MAX) + CMP_W'(1)) * dTot);
    rangeOk = (cand.m1 > cand.m2) &&
              (mSum >= 16'(MSUM_MIN)) && (mSum <= 16'(MSUM_MAX)) &&
              (pSum >= 16'(PSUM_MIN)) && (pSum <= 16'(PSUM_MAX));
  end

  // restoring divider, quotient bounded by DOT_MAX
  logic [CMP_W-1:0] remQ, dsQ;
  logic [QW-1:0]    quoQ;
  logic [CW-1:0]    cntQ;
  logic             ge;

  assign ge = (remQ >= dsQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ <= '0;
      dsQ  <= '0;
      quoQ <= '0;
      cntQ <= '0;
    end else if (strobe.divGo) begin
      remQ <= prod;
      dsQ  <= dTot << (QW - 1);
      quoQ <= '0;
      cntQ <= CW'(QW);
    end else if (cntQ != '0) begin
      if (ge) remQ <= remQ - dsQ;
      quoQ <= (quoQ << 1) | QW'(ge);
      dsQ  <= dsQ >> 1;
      cntQ <= cntQ - 1'b1;
    end
  end

  logic [FREQ_W-1:0] dotF, diff;
  logic              above, take;

  always_comb begin
    dotF  = FREQ_W'(quoQ);
    above = dotF > tgtQ;
    diff  = dotF - tgtQ;
    take  = stat.exact || (above && (diff < bestDiffQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtQ      <= '0;
      refQ      <= '0;
      bestDiffQ <= '1;
      best      <= '0;
      word      <= '0;
      found     <= 1'b0;
    end else if (strobe.load) begin
      tgtQ      <= targetFreq;
      refQ      <= refFreq;
      bestDiffQ <= '1;
      best      <= '0;
      word      <= '0;
      found     <= 1'b0;
    end else if (strobe.judge && take) begin
      best      <= cand;
      word      <= {cand.n - 8'd2, cand.m1 - 8'd2, cand.m2 - 8'd2};
      bestDiffQ <= diff;
      found     <= 1'b1;
    end
  end

  assign stat.candOk  = rangeOk && vcoOk && dotOk;
  assign stat.divDone = (cntQ == '0);
  assign stat.exact   = (dotF == tgtQ);

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_div_search_pkg::*;
#(
  parameter int FREQ_W   = 32,
  parameter int N_MIN    = 3,
  parameter int N_MAX    = 8,
  parameter int M1_MIN   = 10,
  parameter int M1_MAX   = 20,
  parameter int M2_MIN   = 5,
  parameter int M2_MAX   = 9,
  parameter int P1_MIN   = 1,
  parameter int P1_MAX   = 8,
  parameter int P2       = 10,
  parameter int MSUM_MIN = 70,
  parameter int MSUM_MAX = 120,
  parameter int PSUM_MIN = 5,
  parameter int PSUM_MAX = 80,
  parameter logic [FREQ_W-1:0] VCO_MIN = 32'd1400000000,
  parameter logic [FREQ_W-1:0] VCO_MAX = 32'd2800000000,
  parameter logic [FREQ_W-1:0] DOT_MIN = 32'd20000000,
  parameter logic [FREQ_W-1:0] DOT_MAX = 32'd400000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FREQ_W-1:0] targetFreq,
  input  logic [FREQ_W-1:0] refFreq,
  output logic              busy,
  output logic              done,
  output logic              valid,
  output logic [7:0]        nOut,
  output logic [7:0]        m1Out,
  output logic [7:0]        m2Out,
  output logic [7:0]        p1Out,
  output logic [23:0]       divWord
);

  cand_t   cand, best;
  strobe_t strobe;
  status_t stat;
  logic    found;

  pll_div_search_ctrl #(
    .N_MIN(N_MIN), .N_MAX(N_MAX), .M1_MIN(M1_MIN), .M1_MAX(M1_MAX),
    .M2_MIN(M2_MIN), .M2_MAX(M2_MAX), .P1_MIN(P1_MIN), .P1_MAX(P1_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat),
    .cand(cand), .strobe(strobe), .busy(busy), .done(done)
  );

  pll_div_search_dp #(
    .FREQ_W(FREQ_W), .P2(P2), .MSUM_MIN(MSUM_MIN), .MSUM_MAX(MSUM_MAX),
    .PSUM_MIN(PSUM_MIN), .PSUM_MAX(PSUM_MAX), .VCO_MIN(VCO_MIN),
    .VCO_MAX(VCO_MAX), .DOT_MIN(DOT_MIN), .DOT_MAX(DOT_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .targetFreq(targetFreq), .refFreq(refFreq),
    .cand(cand), .strobe(strobe), .stat(stat), .best(best),
    .word(divWord), .found(found)
  );

  assign valid = found && done;
  assign nOut  = best.n;
  assign m1Out = best.m1;
  assign m2Out = best.m2;
  assign p1Out = best.p1;

endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int MSUM_MIN = 70,
  parameter int MSUM_MAX = 120
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        valid,
  input logic [7:0]  nOut,
  input logic [7:0]  m1Out,
  input logic [7:0]  m2Out,
  input logic [23:0] divWord
);

  logic [15:0] mSumOut;
  assign mSumOut = 16'd5 * (16'(m1Out) + 16'd2) + 16'(m2Out) + 16'd2;

  assert_busy_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_valid_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> done);

  assert_none_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !valid) |-> (divWord == 24'd0 && nOut == 8'd0 && m1Out == 8'd0));

  assert_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> (m1Out > m2Out && mSumOut >= 16'(MSUM_MIN) && mSumOut <= 16'(MSUM_MAX)));

  assert_word_pack_R8: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> (divWord == {nOut - 8'd2, m1Out - 8'd2, m2Out - 8'd2}));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(divWord) && $stable(valid)));

endmodule

bind pll_div_search pll_div_search_chk #(
  .MSUM_MIN(MSUM_MIN), .MSUM_MAX(MSUM_MAX)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .valid(valid), .nOut(nOut), .m1Out(m1Out), .m2Out(m2Out), .divWord(divWord)
);

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;

  localparam logic [31:0] VMIN = 32'd1400000;
  localparam logic [31:0] VMAX = 32'd2800000;
  localparam logic [31:0] DMIN = 32'd20000;
  localparam logic [31:0] DMAX = 32'd400000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] targetFreq = '0;
  logic [31:0] refFreq = '0;
  logic        busy, done, valid;
  logic [7:0]  nOut, m1Out, m2Out, p1Out;
  logic [23:0] divWord;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pll_div_search #(
    .FREQ_W(32), .VCO_MIN(VMIN), .VCO_MAX(VMAX), .DOT_MIN(DMIN), .DOT_MAX(DMAX)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .targetFreq(targetFreq),
    .refFreq(refFreq), .busy(busy), .done(done), .valid(valid),
    .nOut(nOut), .m1Out(m1Out), .m2Out(m2Out), .p1Out(p1Out), .divWord(divWord)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference search written from the requirements
  task automatic model(input longint tgt, input longint rf, output int bn, output int bm1,
                       output int bm2, output int bp1, output bit ok);
    longint bestDiff = 64'hFFFFFFFF;
    bit stop = 0;
    bn = 0; bm1 = 0; bm2 = 0; bp1 = 0; ok = 0;
    for (int n = 3; n <= 8 && !stop; n++)
      for (int m1 = 20; m1 >= 10 && !stop; m1--)
        for (int m2 = 9; m2 >= 5 && !stop; m2--)
          for (int p1 = 8; p1 >= 1 && !stop; p1--) begin
            longint m = 5 * (m1 + 2) + (m2 + 2);
            longint p = p1 * 10;
            longint vco = rf * m / (n + 2);
            longint dot = vco / p;
            if (m1 <= m2 || m < 70 || m > 120 || p < 5 || p > 80) continue;
            if (vco < VMIN || vco > VMAX || dot < DMIN || dot > DMAX) continue;
            if (dot == tgt) begin
              bn = n; bm1 = m1; bm2 = m2; bp1 = p1; ok = 1; stop = 1;
            end else if (dot > tgt && dot - tgt < bestDiff) begin
              bn = n; bm1 = m1; bm2 = m2; bp1 = p1; ok = 1; bestDiff = dot - tgt;
            end
          end
  endtask

  task automatic pulseStart(input logic [31:0] t, input logic [31:0] r);
    @(negedge clk);
    targetFreq = t; refFreq = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(done == 1'b0, "R2 done low while busy", done, 0);
  endtask

  task automatic waitDone();
    int cnt = 0;
    while (!done && cnt < 60000) begin
      @(negedge clk);
      cnt++;
    end
    check(done == 1'b1, "R2 search completes", done, 1);
  endtask

  task automatic compare(input longint tgt, input longint rf, input string req);
    int en, em1, em2, ep1;
    bit eok;
    logic [23:0] ew;
    model(tgt, rf, en, em1, em2, ep1, eok);
    ew = eok ? {8'(en - 2), 8'(em1 - 2), 8'(em2 - 2)} : 24'd0;
    check(valid == eok, {req, " valid"}, valid, eok);
    check(nOut == 8'(en), {req, " N"}, nOut, en);
    check(m1Out == 8'(em1), {req, " M1"}, m1Out, em1);
    check(m2Out == 8'(em2), {req, " M2"}, m2Out, em2);
    check(p1Out == 8'(ep1), {req, " P1"}, p1Out, ep1);
    check(divWord == ew, {req, " R8 word"}, divWord, ew);
  endtask

  task automatic testReset();
    check(busy == 0 && done == 0 && valid == 0, "R1 flags", {busy, done, valid}, 0);
    check(divWord == 0 && nOut == 0 && m1Out == 0 && m2Out == 0 && p1Out == 0,
          "R1 outputs", divWord, 0);
  endtask

  task automatic testExact();  // R5 first exact match, R9 formulas
    pulseStart(32'd24000, 32'd96000);
    waitDone();
    compare(24000, 96000, "R5 exact");
    check(nOut == 3 && m1Out == 16 && m2Out == 8 && p1Out == 8, "R5 first in order",
          {nOut, m1Out, m2Out, p1Out}, {8'd3, 8'd16, 8'd8, 8'd8});
  endtask

  task automatic testFallback();  // R6 closest above, R4 legality
    pulseStart(32'd123457, 32'd96000);
    waitDone();
    compare(123457, 96000, "R6 above");
    pulseStart(32'd1000, 32'd96000);
    waitDone();
    compare(1000, 96000, "R6 low target R4");
  endtask

  task automatic testNone();  // R7
    pulseStart(32'd500000, 32'd96000);
    waitDone();
    compare(500000, 96000, "R7 above window");
    check(valid == 0 && divWord == 0, "R7 none", divWord, 0);
    pulseStart(32'd50000, 32'd10000);
    waitDone();
    check(valid == 0 && divWord == 0, "R7 vco window", valid, 0);
  endtask

  task automatic testIgnore();  // R3
    pulseStart(32'd24000, 32'd96000);
    @(negedge clk);
    targetFreq = 32'd1000; refFreq = 32'd48000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R3 still busy", busy, 1);
    waitDone();
    compare(24000, 96000, "R3 ignored start");
  endtask

  task automatic testHold();  // R10
    logic [23:0] w;
    w = divWord;
    targetFreq = 32'd77; refFreq = 32'd5;
    repeat (6) @(negedge clk);
    check(done == 1 && divWord == w && valid == 1, "R10 hold", divWord, w);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testExact();
    testHold();
    testFallback();
    testNone();
    testIgnore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule